// File: doc/BRIEF.md
# Inbound Message Interrupt Pending Collector

This unit sits behind an inbound bus window and turns memory-write message interrupts into a pending bit array that the processor can service. Each inbound write is compared against a fixed register address inside an aligned window. Its data word is split into a vector number and a core-target flag. A write that matches the window, the register offset and this core's identity marks the named vector as pending.

The pending vectors are grouped into 32-bit banks. Software selects a bank, reads it, and clears serviced vectors by writing ones to their positions. One level-sensitive interrupt line goes to the processor's interrupt controller and stays high while any vector anywhere is pending. Software normally walks the banks and handles the lowest set bit of each bank first, but the unit does not enforce that order.

Top module: `msi_pending_unit`

## Requirements
- R1: A message with `msg_valid` high, `msg_addr` equal to 0x0000_0000_FF00_0048, and `msg_data[15]` equal to `core_id` sets pending vector `msg_data[6:0]`. That vector sits in bank `msg_data[6:5]` at bit `msg_data[4:0]`. It is readable on the clock edge after the message, and all other data bits have no effect.
- R2: A message whose low 32 address bits lie outside the 8 KiB window at 0xFF00_0000, or that targets any offset other than 0x48 inside the window, changes no pending bit.
- R3: A message with any of address bits [63:32] set changes no pending bit.
- R4: A message whose `msg_data[15]` differs from `core_id` changes no pending bit. This holds for both values of `core_id`.
- R5: A register write with `reg_we` high clears each bit of bank `reg_sel` where `reg_wdata` is 1. Bits where `reg_wdata` is 0 keep their value.
- R6: When an accepted message and a clear write hit the same vector in the same cycle, the vector ends up pending. Other bits cleared by that write still clear.
- R7: Repeated messages to a vector that is already pending leave a single pending bit, which one clear removes.
- R8: `irq_o` is high exactly while at least one of the 128 pending bits is set. It follows the pending array without added delay in the default configuration.
- R9: Reset (`rst_n` low, asynchronous) clears every pending bit and drives `irq_o` low.
- R10: `reg_rdata` shows bank `reg_sel` combinationally. Bank k holds vectors 32k through 32k+31, with vector 32k at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_id | input | 1 | Identity this unit accepts in data bit 15 |
| msg_valid | input | 1 | Inbound message write strobe |
| msg_addr | input | 64 | Inbound write address |
| msg_data | input | 32 | Inbound write data |
| reg_sel | input | 2 | Bank select for register read and clear |
| reg_we | input | 1 | Write-one-to-clear strobe for bank `reg_sel` |
| reg_wdata | input | 32 | Clear mask |
| reg_rdata | output | 32 | Contents of bank `reg_sel` |
| irq_o | output | 1 | Level summary interrupt |

## Verification
The assertions assume that `core_id` is steady around each message and that an inbound message and a register write each last exactly one cycle. They also assume that reset is released away from a clock edge. The bench drives every input at the falling edge, holds `core_id` constant across each message, and returns `msg_valid` and `reg_we` to low after a single cycle. This keeps the one-cycle set and clear relations that the bank checks rely on well defined. Coincident set and clear are produced only on purpose, in the directed test for R6.

// File: rtl/msi_pend_pkg.sv
package msi_pend_pkg;
   localparam int unsigned DEF_VECTORS   = 128;
   localparam int unsigned DEF_BANK_W    = 32;
   localparam logic [31:0] DEF_WIN_BASE  = 32'hFF00_0000;
   localparam int unsigned DEF_WIN_BYTES = 8192;
   localparam logic [31:0] DEF_MSG_OFS   = 32'h0000_0048;
   localparam int unsigned DEF_CORE_BIT  = 15;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/msi_msg_decode.sv
module msi_msg_decode #(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned VEC_W     = 7,
   parameter logic [31:0] WIN_BASE  = msi_pend_pkg::DEF_WIN_BASE,
   parameter int unsigned WIN_BYTES = msi_pend_pkg::DEF_WIN_BYTES,
   parameter logic [31:0] MSG_OFS   = msi_pend_pkg::DEF_MSG_OFS,
   parameter int unsigned CORE_BIT  = msi_pend_pkg::DEF_CORE_BIT
) (
   input  logic              msg_valid,
   input  logic [ADDR_W-1:0] msg_addr,
   input  logic [DATA_W-1:0] msg_data,
   input  logic              core_id,
   output logic              accept,
   output logic [VEC_W-1:0]  vec
);
   localparam int unsigned LOW_W   = 32;
   localparam int unsigned WIN_LSB = $clog2(WIN_BYTES);

   logic upper_zero;
   logic in_window;
   logic at_offset;
   logic core_hit;
   logic unused_data_bits;

   generate
      if (ADDR_W > LOW_W) begin : g_wide
         assign upper_zero = (msg_addr[ADDR_W-1:LOW_W] == '0);
      end else begin : g_narrow
         assign upper_zero = 1'b1;
      end
      if (!msi_pend_pkg::is_pow2(WIN_BYTES) || WIN_LSB >= LOW_W) begin : g_bad_win
         $error("window size must be a power of two below 4 GiB");
      end
      if (MSG_OFS >= WIN_BYTES) begin : g_bad_ofs
         $error("message register offset lies outside the window");
      end
      if (CORE_BIT >= DATA_W || VEC_W > CORE_BIT) begin : g_bad_core
         $error("core select bit overlaps vector field or data width");
      end
      if (ADDR_W < LOW_W) begin : g_bad_addr
         $error("address must be at least 32 bits");
      end
   endgenerate

   assign in_window = (msg_addr[LOW_W-1:WIN_LSB] == WIN_BASE[LOW_W-1:WIN_LSB]);
   assign at_offset = (msg_addr[WIN_LSB-1:0] == MSG_OFS[WIN_LSB-1:0]);
   assign core_hit  = (msg_data[CORE_BIT] == core_id);

   assign accept = msg_valid && upper_zero && in_window && at_offset && core_hit;
   assign vec    = msg_data[VEC_W-1:0];

   assign unused_data_bits = ^msg_data;
endmodule

// File: rtl/msi_pend_bank.sv
module msi_pend_bank #(
   parameter int unsigned BANK_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] set_mask,
   input  logic [BANK_W-1:0] clr_mask,
   output logic [BANK_W-1:0] pend_q
);
   logic [BANK_W-1:0] pend_d;

   always_comb begin
      pend_d = (pend_q & ~clr_mask) | set_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   // R6
   set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mask != '0) |=> ((pend_q & $past(set_mask)) == $past(set_mask)));

   // R5
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_mask & ~set_mask) != '0) |=> ((pend_q & $past(clr_mask & ~set_mask)) == '0));

   // R5
   untouched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & ~$past(set_mask | clr_mask)) ==
                ($past(pend_q) & ~$past(set_mask | clr_mask))));
endmodule

// File: rtl/msi_summary.sv
module msi_summary #(
   parameter int unsigned WIDTH   = 128,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pend,
   output logic             irq
);
   logic any_set;
   assign any_set = |pend;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= any_set;
         end
      end else begin : g_comb
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign irq = any_set;
      end
   endgenerate
endmodule

// File: rtl/msi_pending_unit.sv
module msi_pending_unit #(
   parameter int unsigned ADDR_W      = 64,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NUM_VEC     = msi_pend_pkg::DEF_VECTORS,
   parameter int unsigned BANK_W      = msi_pend_pkg::DEF_BANK_W,
   parameter logic [31:0] WIN_BASE    = msi_pend_pkg::DEF_WIN_BASE,
   parameter int unsigned WIN_BYTES   = msi_pend_pkg::DEF_WIN_BYTES,
   parameter logic [31:0] MSG_OFS     = msi_pend_pkg::DEF_MSG_OFS,
   parameter int unsigned CORE_BIT    = msi_pend_pkg::DEF_CORE_BIT,
   parameter bit          REG_SUMMARY = 1'b0,
   localparam int unsigned NUM_BANKS  = NUM_VEC / BANK_W,
   localparam int unsigned SEL_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_id,
   input  logic              msg_valid,
   input  logic [ADDR_W-1:0] msg_addr,
   input  logic [DATA_W-1:0] msg_data,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic              reg_we,
   input  logic [BANK_W-1:0] reg_wdata,
   output logic [BANK_W-1:0] reg_rdata,
   output logic              irq_o
);
   localparam int unsigned VEC_W = $clog2(NUM_VEC);
   localparam int unsigned BIT_W = $clog2(BANK_W);

   generate
      if (!msi_pend_pkg::is_pow2(NUM_VEC) || !msi_pend_pkg::is_pow2(BANK_W)) begin : g_bad_pow
         $error("vector count and bank width must be powers of two");
      end
      if (NUM_BANKS < 2) begin : g_bad_banks
         $error("at least two banks are required");
      end
   endgenerate

   logic              accept;
   logic [VEC_W-1:0]  vec;
   logic [BANK_W-1:0] pend [NUM_BANKS];
   logic [NUM_VEC-1:0] pend_flat;

   msi_msg_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W), .WIN_BASE(WIN_BASE),
      .WIN_BYTES(WIN_BYTES), .MSG_OFS(MSG_OFS), .CORE_BIT(CORE_BIT)
   ) i_decode (
      .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
      .core_id(core_id), .accept(accept), .vec(vec)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic [BANK_W-1:0] set_mask;
         logic [BANK_W-1:0] clr_mask;

         always_comb begin
            set_mask = '0;
            if (accept && (vec[VEC_W-1:BIT_W] == SEL_W'(b)))
               set_mask = BANK_W'(1) << vec[BIT_W-1:0];
            clr_mask = (reg_we && (reg_sel == SEL_W'(b))) ? reg_wdata : '0;
         end

         msi_pend_bank #(.BANK_W(BANK_W)) i_bank (
            .clk(clk), .rst_n(rst_n), .set_mask(set_mask),
            .clr_mask(clr_mask), .pend_q(pend[b])
         );

         assign pend_flat[b*BANK_W +: BANK_W] = pend[b];
      end
   endgenerate

   assign reg_rdata = pend[reg_sel];

   msi_summary #(.WIDTH(NUM_VEC), .REG_OUT(REG_SUMMARY)) i_summary (
      .clk(clk), .rst_n(rst_n), .pend(pend_flat), .irq(irq_o)
   );

   // R9
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !irq_o);

   generate
      if (REG_SUMMARY) begin : g_rise_reg
         // R8
         irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o) |-> $past(accept, 2));
      end else begin : g_rise_comb
         // R8
         irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o) |-> $past(accept));
      end
   endgenerate
endmodule

// File: tb/test_msi_pending_unit.sv
`timescale 1ns/1ps
module test_msi_pending_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        core_id = 1'b0;
   logic        msg_valid = 1'b0;
   logic [63:0] msg_addr = '0;
   logic [31:0] msg_data = '0;
   logic [1:0]  reg_sel = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o;

   int errors = 0;
   int checks = 0;
   logic [31:0] exp_bank [4];

   always #2.5 clk = ~clk;

   msi_pending_unit i_msi_pending_unit (
      .clk(clk), .rst_n(rst_n), .core_id(core_id), .msg_valid(msg_valid),
      .msg_addr(msg_addr), .msg_data(msg_data), .reg_sel(reg_sel),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   localparam int NT = 9;
   localparam logic [63:0] T_ADDR [NT] = '{
      64'h0000_0000_FF00_0048, 64'h0000_0000_FF00_0048, 64'h0000_0000_FF00_0048,
      64'h0000_0000_FF00_0048, 64'h0000_0000_FF00_004C, 64'h0000_0000_FE00_0048,
      64'h0000_0000_FF00_2048, 64'h0000_0001_FF00_0048, 64'h0000_0000_FF00_0048};
   localparam logic [31:0] T_DATA [NT] = '{
      32'h0000_0005, 32'h0000_002A, 32'h0000_007F, 32'h0000_8003, 32'h0000_0003,
      32'h0000_0003, 32'h0000_0003, 32'h0000_0003, 32'hFFFF_7F40};
   localparam bit T_ACC [NT] = '{1, 1, 1, 0, 0, 0, 0, 0, 1};
   localparam int T_VEC [NT] = '{5, 42, 127, 3, 3, 3, 3, 3, 64};
   localparam string T_REQ [NT] = '{"R1", "R1", "R1", "R4", "R2", "R2", "R2", "R3", "R1"};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic mv, input logic [63:0] a, input logic [31:0] d,
                        input logic we, input logic [1:0] sel, input logic [31:0] wd);
      @(negedge clk);
      msg_valid = mv; msg_addr = a; msg_data = d;
      reg_we = we; reg_sel = sel; reg_wdata = wd;
      @(negedge clk);
      msg_valid = 1'b0; reg_we = 1'b0;
   endtask

   task automatic send(input logic [63:0] a, input logic [31:0] d);
      drive(1'b1, a, d, 1'b0, 2'd0, 32'h0);
   endtask

   task automatic clear(input logic [1:0] sel, input logic [31:0] m);
      drive(1'b0, 64'h0, 32'h0, 1'b1, sel, m);
   endtask

   task automatic check_all(input string req);
      logic any;
      any = 1'b0;
      for (int k = 0; k < 4; k++) begin
         reg_sel = 2'(k);
         #0.2;
         check(req, reg_rdata, exp_bank[k]);
         any = any | (|exp_bank[k]);
      end
      check("R8", {31'h0, irq_o}, {31'h0, any});
   endtask

   task automatic wipe();
      for (int k = 0; k < 4; k++) begin
         clear(2'(k), 32'hFFFF_FFFF);
         exp_bank[k] = '0;
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      for (int k = 0; k < 4; k++) exp_bank[k] = '0;
      #12.5;
      // R9, R10 reset state
      check_all("R9");
      @(negedge clk); rst_n = 1'b1;

      // table walk: R1 R2 R3 R4 R10
      for (int i = 0; i < NT; i++) begin
         send(T_ADDR[i], T_DATA[i]);
         if (T_ACC[i]) exp_bank[T_VEC[i] / 32][T_VEC[i] % 32] = 1'b1;
         check_all(T_REQ[i]);
         wipe();
         check_all("R5");
      end

      // R5: zeros keep, ones clear
      send(64'hFF00_0048, 32'h3);
      send(64'hFF00_0048, 32'h7);
      exp_bank[0] = 32'h88;
      clear(2'd0, 32'h0);
      check_all("R5");
      clear(2'd0, 32'h8);
      exp_bank[0] = 32'h80;
      check_all("R5");
      clear(2'd0, 32'h80);
      exp_bank[0] = 32'h0;
      check_all("R8");

      // R6: set wins over a coincident clear
      send(64'hFF00_0048, 32'h21);
      send(64'hFF00_0048, 32'h22);
      drive(1'b1, 64'hFF00_0048, 32'h21, 1'b1, 2'd1, 32'h6);
      exp_bank[1] = 32'h2;
      check_all("R6");
      wipe();

      // R7: repeated messages merge
      for (int r = 0; r < 3; r++) send(64'hFF00_0048, 32'h64);
      exp_bank[3] = 32'h10;
      check_all("R7");
      clear(2'd3, 32'h10);
      exp_bank[3] = 32'h0;
      check_all("R7");

      // R4 with the other core identity
      core_id = 1'b1;
      send(64'hFF00_0048, 32'h0000_0009);
      check_all("R4");
      send(64'hFF00_0048, 32'h8000_8009);
      exp_bank[0] = 32'h200;
      check_all("R4");
      core_id = 1'b0;

      // R9: reset during operation
      send(64'hFF00_0048, 32'h50);
      @(negedge clk); rst_n = 1'b0;
      for (int k = 0; k < 4; k++) exp_bank[k] = '0;
      #1;
      check_all("R9");
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule